// File: doc/BRIEF.md
# Chained Memory Descriptor Walker

This block builds the page list of a memory region by reading a table of descriptors held in system memory. Software names a region by writing its ID. It then writes the page number of the first descriptor page. Writing zero there deletes the region at once. Writing a nonzero page number clears the region and starts a walk. The walk fetches 64-bit entries one at a time over a plain read request/response port and handles each entry in one of three ways. It appends a run of pages to the region's range store, it jumps to the start of another descriptor page, or it ends the list.

A walk ends with a one-cycle `done` pulse. `error` stays high from a failed operation until the next descriptor write that is accepted. The walk fails if the region ID is out of range, if the entry budget is used up, if the walk runs off the end of a page, if the range store fills, or if an entry is malformed. A failed walk leaves the region marked invalid. Two constant outputs give the number of supported IDs and the entry budget. A combinational query port reads back any region's state and stored ranges.

The parameters `ID_W`, `RIDX_W`, `LEN_W` and `ADDR_W` are derived and must not be overridden. `NUM_IDS` must be at least 2.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `memReqValid` are low, and every region reads back as invalid with zero ranges.
- R2: Writing the ID register has no visible effect: no request is issued and `busy` stays low. A descriptor write acts on the ID written most recently, captured when the write is accepted.
- R3: A descriptor write of zero to an in-range ID makes the region invalid with zero ranges, clears `error` and pulses `done` in the next cycle, without any memory request.
- R4: Entry i of page p is fetched from byte address p*2^PAGE_SHIFT + i*8. Response bits [31:0] hold the page number and bits [63:32] hold the page count. A request stays asserted with a stable address until `memReqReady` is high.
- R5: An entry with a nonzero page number and a nonzero count is appended to the region's range store, in walk order. While a walk is running, the region reads as invalid.
- R6: An entry with both words zero ends the walk. The region becomes valid, `done` pulses, `busy` drops and `error` stays low.
- R7: An entry with a nonzero page number and a zero count makes the next fetch come from index 0 of the named page.
- R8: If a page-run entry sits in the last slot of a page, the walk ends in error. The walk never moves on to the next page by itself.
- R9: At most MAX_ENTRIES entries are fetched for one region. When the budget is used up without a terminator, the walk ends in error.
- R10: A descriptor write while the latched ID is NUM_IDS or more pulses `done` with `error` set. It issues no request and changes no region.
- R11: The walk ends in error and leaves the region invalid if the range store is full when another page run arrives, or if an entry has page number zero and a nonzero count. `error` holds until the next accepted descriptor write.
- R12: While `busy` is high, descriptor writes are ignored. The walk still finishes on the region it started with.
- R13: `maxIds` reads NUM_IDS and `maxEntries` reads MAX_ENTRIES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idWrite | input | 1 | Strobe: load `wrData` into the ID register |
| descWrite | input | 1 | Strobe: descriptor-page write of `wrData` |
| wrData | input | 32 | Write data for both registers |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last operation failed |
| maxIds | output | 32 | Number of supported region IDs |
| maxEntries | output | 32 | Entry budget per region |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | ADDR_W | Byte address of the entry |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Entry: count in [63:32], page in [31:0] |
| qryId | input | ID_W | Region to inspect |
| qryIdx | input | RIDX_W | Range slot to inspect |
| qryValid | output | 1 | Region is valid |
| qryLen | output | LEN_W | Number of stored ranges |
| qryPpn | output | 32 | First page of the selected range |
| qryPages | output | 32 | Page count of the selected range |

## Verification
The checks assume that the memory side returns exactly one response for each accepted request, and only while the walker is waiting for one. They also assume that a response never arrives in the same cycle as its request. The bench memory model keeps to this. It accepts a request only when ready is high, and it answers a fixed three cycles later. Ready toggles every cycle, so requests are held across refused cycles. Descriptor tables are written into a sparse bench memory. Any slot that was not written reads as a terminator.

// File: rtl/walker_pkg.sv
package walker_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clearRegion;  // invalidate the region named by the ID register
    logic loadStart;    // latch region and first page, zero index and count
    logic advance;      // step to the next slot of the page
    logic follow;       // jump to slot 0 of the page named in the response
    logic append;       // store the response as a page run
    logic commit;       // mark the walked region valid
  } walkCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walkState_t;

endpackage

// File: rtl/desc_walk_dp.sv
module desc_walk_dp
  import walker_pkg::*;
#(
  parameter int NUM_IDS     = 8,
  parameter int MAX_RANGES  = 16,
  parameter int MAX_ENTRIES = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int ID_W        = $clog2(NUM_IDS),
  parameter int RIDX_W      = $clog2(MAX_RANGES),
  parameter int LEN_W       = $clog2(MAX_RANGES + 1),
  parameter int ADDR_W      = 32 + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic              idWrite,
  input  logic [31:0]       wrData,
  input  logic [63:0]       rspData,
  input  logic [ID_W-1:0]   qryId,
  input  logic [RIDX_W-1:0] qryIdx,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              idInRange,
  output logic              cntAtLimit,
  output logic              idxLast,
  output logic              storeFull,
  output logic              qryValid,
  output logic [LEN_W-1:0]  qryLen,
  output logic [31:0]       qryPpn,
  output logic [31:0]       qryPages
);

  localparam int IDX_W = PAGE_SHIFT - 3;
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1);

  logic [31:0]       curId;
  logic [ID_W-1:0]   walkId;
  logic [31:0]       pagePpn;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  entryCnt;
  logic [31:0]       rngPpn   [NUM_IDS][MAX_RANGES];
  logic [31:0]       rngPages [NUM_IDS][MAX_RANGES];
  logic [LEN_W-1:0]  rngLen   [NUM_IDS];
  logic [NUM_IDS-1:0] regValid;

  logic [31:0] rspPpn;
  logic [31:0] rspCnt;
  assign rspPpn = rspData[31:0];
  assign rspCnt = rspData[63:32];

  assign idInRange  = curId < 32'(NUM_IDS);
  assign cntAtLimit = entryCnt == CNT_W'(MAX_ENTRIES);
  assign idxLast    = &idx;
  assign storeFull  = rngLen[walkId] == LEN_W'(MAX_RANGES);
  assign reqAddr    = {pagePpn, idx, 3'b000};

  // Walk pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curId    <= '0;
      walkId   <= '0;
      pagePpn  <= '0;
      idx      <= '0;
      entryCnt <= '0;
    end else begin
      if (idWrite) curId <= wrData;
      if (ctl.loadStart) begin
        walkId   <= curId[ID_W-1:0];
        pagePpn  <= wrData;
        idx      <= '0;
        entryCnt <= '0;
      end else if (ctl.follow) begin
        pagePpn  <= rspPpn;
        idx      <= '0;
        entryCnt <= entryCnt + 1'b1;
      end else if (ctl.advance) begin
        idx      <= idx + 1'b1;
        entryCnt <= entryCnt + 1'b1;
      end
    end
  end

  // Region state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regValid <= '0;
      for (int i = 0; i < NUM_IDS; i++) rngLen[i] <= '0;
    end else begin
      if (ctl.clearRegion) begin
        regValid[curId[ID_W-1:0]] <= 1'b0;
        rngLen[curId[ID_W-1:0]]   <= '0;
      end
      if (ctl.append) rngLen[walkId] <= rngLen[walkId] + 1'b1;
      if (ctl.commit) regValid[walkId] <= 1'b1;
    end
  end

  // Range contents, guarded by rngLen
  always_ff @(posedge clk) begin
    if (ctl.append) begin
      rngPpn[walkId][rngLen[walkId][RIDX_W-1:0]]   <= rspPpn;
      rngPages[walkId][rngLen[walkId][RIDX_W-1:0]] <= rspCnt;
    end
  end

  always_comb begin
    qryValid = regValid[qryId];
    qryLen   = rngLen[qryId];
    qryPpn   = '0;
    qryPages = '0;
    if (int'(qryIdx) < MAX_RANGES) begin
      qryPpn   = rngPpn[qryId][qryIdx];
      qryPages = rngPages[qryId][qryIdx];
    end
  end

  AST_ENTRY_CAP: assert property (@(posedge clk) disable iff (!rstN)
    entryCnt <= CNT_W'(MAX_ENTRIES)); // R9

  AST_APPEND_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    ctl.append |-> !regValid[walkId]); // R5

  for (genvar g = 0; g < NUM_IDS; g++) begin : gLenCap
    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rstN)
      rngLen[g] <= LEN_W'(MAX_RANGES)); // R11
  end

endmodule

// File: rtl/desc_walk_ctrl.sv
module desc_walk_ctrl
  import walker_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     descWrite,
  input  logic     wrNonZero,
  input  logic     idInRange,
  input  logic     cntAtLimit,
  input  logic     idxLast,
  input  logic     storeFull,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     rspPpnZero,
  input  logic     rspCntZero,
  output walkCtl_t ctl,
  output logic     memReqValid,
  output logic     busy,
  output logic     done,
  output logic     error
);

  walkState_t state, nState;
  logic setDone, setErr, clrErr;

  always_comb begin
    ctl         = '0;
    nState      = state;
    setDone     = 1'b0;
    setErr      = 1'b0;
    clrErr      = 1'b0;
    memReqValid = 1'b0;
    case (state)
      ST_IDLE: begin
        if (descWrite) begin
          if (!idInRange) begin
            setDone = 1'b1;
            setErr  = 1'b1;
          end else begin
            clrErr          = 1'b1;
            ctl.clearRegion = 1'b1;
            if (!wrNonZero) begin
              setDone = 1'b1;
            end else begin
              ctl.loadStart = 1'b1;
              nState        = ST_REQ;
            end
          end
        end
      end
      ST_REQ: begin
        if (cntAtLimit) begin
          setErr  = 1'b1;
          setDone = 1'b1;
          nState  = ST_IDLE;
        end else begin
          memReqValid = 1'b1;
          if (memReqReady) nState = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (memRspValid) begin
          case ({rspPpnZero, rspCntZero})
            2'b11: begin
              ctl.commit = 1'b1;
              setDone    = 1'b1;
              nState     = ST_IDLE;
            end
            2'b10: begin
              setErr  = 1'b1;
              setDone = 1'b1;
              nState  = ST_IDLE;
            end
            2'b01: begin
              ctl.follow = 1'b1;
              nState     = ST_REQ;
            end
            default: begin
              if (storeFull) begin
                setErr  = 1'b1;
                setDone = 1'b1;
                nState  = ST_IDLE;
              end else begin
                ctl.append = 1'b1;
                if (idxLast) begin
                  setErr  = 1'b1;
                  setDone = 1'b1;
                  nState  = ST_IDLE;
                end else begin
                  ctl.advance = 1'b1;
                  nState      = ST_REQ;
                end
              end
            end
          endcase
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nState;
      done  <= setDone;
      if (setErr)      error <= 1'b1;
      else if (clrErr) error <= 1'b0;
    end
  end

  assign busy = state != ST_IDLE;

  AST_RSP_WAITING: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> state == ST_WAIT); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    error && !descWrite |=> error); // R11

endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
  import walker_pkg::*;
#(
  parameter int NUM_IDS     = 8,
  parameter int MAX_RANGES  = 16,
  parameter int MAX_ENTRIES = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int ID_W        = $clog2(NUM_IDS),
  parameter int RIDX_W      = $clog2(MAX_RANGES),
  parameter int LEN_W       = $clog2(MAX_RANGES + 1),
  parameter int ADDR_W      = 32 + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idWrite,
  input  logic              descWrite,
  input  logic [31:0]       wrData,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [31:0]       maxIds,
  output logic [31:0]       maxEntries,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [63:0]       memRspData,
  input  logic [ID_W-1:0]   qryId,
  input  logic [RIDX_W-1:0] qryIdx,
  output logic              qryValid,
  output logic [LEN_W-1:0]  qryLen,
  output logic [31:0]       qryPpn,
  output logic [31:0]       qryPages
);

  walkCtl_t ctl;
  logic idInRange, cntAtLimit, idxLast, storeFull;

  assign maxIds     = 32'(NUM_IDS);
  assign maxEntries = 32'(MAX_ENTRIES);

  desc_walk_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .descWrite  (descWrite),
    .wrNonZero  (|wrData),
    .idInRange  (idInRange),
    .cntAtLimit (cntAtLimit),
    .idxLast    (idxLast),
    .storeFull  (storeFull),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .rspPpnZero (memRspData[31:0] == 32'd0),
    .rspCntZero (memRspData[63:32] == 32'd0),
    .ctl        (ctl),
    .memReqValid(memReqValid),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  desc_walk_dp #(
    .NUM_IDS    (NUM_IDS),
    .MAX_RANGES (MAX_RANGES),
    .MAX_ENTRIES(MAX_ENTRIES),
    .PAGE_SHIFT (PAGE_SHIFT),
    .ID_W       (ID_W),
    .RIDX_W     (RIDX_W),
    .LEN_W      (LEN_W),
    .ADDR_W     (ADDR_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .idWrite   (idWrite),
    .wrData    (wrData),
    .rspData   (memRspData),
    .qryId     (qryId),
    .qryIdx    (qryIdx),
    .reqAddr   (memReqAddr),
    .idInRange (idInRange),
    .cntAtLimit(cntAtLimit),
    .idxLast   (idxLast),
    .storeFull (storeFull),
    .qryValid  (qryValid),
    .qryLen    (qryLen),
    .qryPpn    (qryPpn),
    .qryPages  (qryPages)
  );

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)); // R4

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'b000); // R4

endmodule

// File: tb/test_desc_chain_walker.sv
module test_desc_chain_walker;

  localparam int NIDS = 4;
  localparam int NRNG = 20;
  localparam int NENT = 24;
  localparam int PS   = 7;
  localparam int IDW  = $clog2(NIDS);
  localparam int RIW  = $clog2(NRNG);
  localparam int LNW  = $clog2(NRNG + 1);
  localparam int AW   = 32 + PS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idWrite = 1'b0, descWrite = 1'b0;
  logic [31:0] wrData = '0;
  logic busy, done, error;
  logic [31:0] maxIds, maxEntries;
  logic memReqValid;
  logic memReqReady = 1'b0;
  logic [AW-1:0] memReqAddr;
  logic memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic [IDW-1:0] qryId = '0;
  logic [RIW-1:0] qryIdx = '0;
  logic qryValid;
  logic [LNW-1:0] qryLen;
  logic [31:0] qryPpn, qryPages;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  desc_chain_walker #(
    .NUM_IDS(NIDS), .MAX_RANGES(NRNG), .MAX_ENTRIES(NENT), .PAGE_SHIFT(PS)
  ) i_desc_chain_walker (
    .clk(clk), .rstN(rstN), .idWrite(idWrite), .descWrite(descWrite), .wrData(wrData),
    .busy(busy), .done(done), .error(error), .maxIds(maxIds), .maxEntries(maxEntries),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .qryId(qryId), .qryIdx(qryIdx), .qryValid(qryValid), .qryLen(qryLen),
    .qryPpn(qryPpn), .qryPages(qryPages)
  );

  // Sparse descriptor memory; unwritten slots read as terminators
  logic [63:0] mem [longint];
  logic [AW-1:0] addrLog [256];
  int addrTot = 0;
  logic [AW-1:0] pendAddr = '0;
  int pendCnt = 0;

  function automatic logic [63:0] memRead(logic [AW-1:0] a);
    longint k = longint'(a);
    return mem.exists(k) ? mem[k] : 64'd0;
  endfunction

  task automatic putEntry(int ppn, int slot, int pg, int cnt);
    mem[longint'(ppn) * (1 << PS) + slot * 8] = {32'(cnt), 32'(pg)};
  endtask

  function automatic logic [AW-1:0] entAddr(int ppn, int slot);
    return AW'(longint'(ppn) * (1 << PS) + slot * 8);
  endfunction

  always @(negedge clk) memReqReady <= ~memReqReady;

  always @(posedge clk) begin
    if (!rstN) begin
      pendCnt     <= 0;
      memRspValid <= 1'b0;
    end else begin
      if (memReqValid && memReqReady) begin
        pendAddr <= memReqAddr;
        pendCnt  <= 3;
        addrLog[addrTot[7:0]] <= memReqAddr;
        addrTot  <= addrTot + 1;
      end else if (pendCnt != 0) begin
        pendCnt <= pendCnt - 1;
      end
      memRspValid <= (pendCnt == 1);
      memRspData  <= memRead(pendAddr);
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic writeId(logic [31:0] v);
    @(negedge clk); idWrite = 1'b1; wrData = v;
    @(negedge clk); idWrite = 1'b0;
  endtask

  // Pulses a descriptor write; returns at the negedge after the write edge
  task automatic writeDesc(logic [31:0] v);
    @(negedge clk); descWrite = 1'b1; wrData = v;
    @(negedge clk); descWrite = 1'b0;
  endtask

  task automatic waitDone(string req);
    bit seen = 0;
    for (int i = 0; i < 2000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    check(req, "done seen", 64'(seen), 64'd1);
    check(req, "busy low at done", 64'(busy), 64'd0);
  endtask

  task automatic region(string req, int id, bit v, int len);
    qryId = IDW'(id); #1;
    check(req, $sformatf("region %0d valid", id), 64'(qryValid), 64'(v));
    check(req, $sformatf("region %0d length", id), 64'(qryLen), 64'(len));
  endtask

  task automatic rangeAt(string req, int id, int slot, int pg, int cnt);
    qryId = IDW'(id); qryIdx = RIW'(slot); #1;
    check(req, $sformatf("range %0d.%0d page", id, slot), 64'(qryPpn), 64'(pg));
    check(req, $sformatf("range %0d.%0d count", id, slot), 64'(qryPages), 64'(cnt));
  endtask

  task automatic testReset();
    check("R1", "busy", 64'(busy), 0);
    check("R1", "done", 64'(done), 0);
    check("R1", "error", 64'(error), 0);
    check("R1", "request", 64'(memReqValid), 0);
    for (int i = 0; i < NIDS; i++) region("R1", i, 0, 0);
    check("R13", "maxIds", 64'(maxIds), NIDS);
    check("R13", "maxEntries", 64'(maxEntries), NENT);
  endtask

  task automatic testBasicWalk();
    int base;
    putEntry(1, 0, 100, 3);
    putEntry(1, 1, 200, 5);
    writeId(1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R2", "busy after id write", 64'(busy), 0);
      check("R2", "request after id write", 64'(memReqValid), 0);
    end
    writeId(2);
    base = addrTot;
    writeDesc(1);
    waitDone("R6");
    check("R6", "error", 64'(error), 0);
    check("R4", "reads", 64'(addrTot - base), 3);
    for (int i = 0; i < 3; i++)
      check("R4", $sformatf("address %0d", i), 64'(addrLog[base + i]), 64'(entAddr(1, i)));
    region("R6", 2, 1, 2);
    region("R2", 1, 0, 0);
    rangeAt("R5", 2, 0, 100, 3);
    rangeAt("R5", 2, 1, 200, 5);
  endtask

  task automatic testChain();
    int base;
    putEntry(3, 0, 300, 1);
    putEntry(3, 1, 4, 0);
    putEntry(4, 0, 400, 2);
    writeId(1);
    base = addrTot;
    writeDesc(3);
    waitDone("R7");
    check("R7", "error", 64'(error), 0);
    check("R7", "reads", 64'(addrTot - base), 4);
    check("R7", "addr 0", 64'(addrLog[base]),     64'(entAddr(3, 0)));
    check("R7", "addr 1", 64'(addrLog[base + 1]), 64'(entAddr(3, 1)));
    check("R7", "addr 2", 64'(addrLog[base + 2]), 64'(entAddr(4, 0)));
    check("R7", "addr 3", 64'(addrLog[base + 3]), 64'(entAddr(4, 1)));
    region("R7", 1, 1, 2);
    rangeAt("R5", 1, 0, 300, 1);
    rangeAt("R5", 1, 1, 400, 2);
  endtask

  task automatic testDelete();
    int base;
    writeId(2);
    base = addrTot;
    writeDesc(0);
    check("R3", "done next cycle", 64'(done), 1);
    check("R3", "error", 64'(error), 0);
    check("R3", "no read", 64'(addrTot - base), 0);
    region("R3", 2, 0, 0);
    region("R3", 1, 1, 2);
  endtask

  task automatic testOverrun();
    int base;
    for (int i = 0; i < (1 << (PS - 3)); i++) putEntry(5, i, 500 + i, 1);
    writeId(3);
    base = addrTot;
    writeDesc(5);
    waitDone("R8");
    check("R8", "error", 64'(error), 1);
    check("R8", "reads", 64'(addrTot - base), 1 << (PS - 3));
    check("R8", "last addr", 64'(addrLog[addrTot - 1]), 64'(entAddr(5, (1 << (PS - 3)) - 1)));
    region("R11", 3, 0, 1 << (PS - 3));
    // error clears on the next accepted write
    writeDesc(0);
    check("R3", "error cleared", 64'(error), 0);
  endtask

  task automatic testEntryLimit();
    int base;
    putEntry(6, 0, 6, 0);
    writeId(0);
    base = addrTot;
    writeDesc(6);
    waitDone("R9");
    check("R9", "error", 64'(error), 1);
    check("R9", "reads", 64'(addrTot - base), NENT);
    region("R9", 0, 0, 0);
  endtask

  task automatic testStoreFull();
    int base;
    for (int i = 0; i < 15; i++) putEntry(7, i, 700 + i, 2);
    putEntry(7, 15, 8, 0);
    for (int i = 0; i < 6; i++) putEntry(8, i, 800 + i, 2);
    writeId(0);
    base = addrTot;
    writeDesc(7);
    waitDone("R11");
    check("R11", "error", 64'(error), 1);
    check("R11", "reads", 64'(addrTot - base), 22);
    region("R11", 0, 0, NRNG);
  endtask

  task automatic testBadEntry();
    putEntry(9, 0, 0, 5);
    writeId(2);
    writeDesc(9);
    waitDone("R11");
    check("R11", "bad entry error", 64'(error), 1);
    region("R11", 2, 0, 0);
  endtask

  task automatic testBadId();
    int base;
    writeId(NIDS);
    base = addrTot;
    writeDesc(1);
    check("R10", "done", 64'(done), 1);
    check("R10", "error", 64'(error), 1);
    writeId(32'hFFFF_FFFF);
    writeDesc(1);
    check("R10", "done max id", 64'(done), 1);
    check("R10", "error max id", 64'(error), 1);
    check("R10", "no read", 64'(addrTot - base), 0);
    region("R10", 1, 1, 2);
  endtask

  task automatic testBusyBlock();
    writeId(2);
    writeDesc(1);
    waitDone("R12");
    region("R12", 2, 1, 2);
    writeId(1);
    writeDesc(3);
    check("R12", "busy", 64'(busy), 1);
    writeId(2);
    writeDesc(0);
    check("R12", "still busy", 64'(busy), 1);
    waitDone("R12");
    check("R12", "error", 64'(error), 0);
    region("R12", 2, 1, 2);
    region("R12", 1, 1, 2);
    rangeAt("R12", 1, 1, 400, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicWalk();
    testChain();
    testDelete();
    testOverrun();
    testEntryLimit();
    testStoreFull();
    testBadEntry();
    testBadId();
    testBusyBlock();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule